// File: doc/BRIEF.md
# I2C SCL Clock Generator with Rise Compensation

This block produces the SCL waveform for an I2C controller from the peripheral clock. A prescaler divides the input clock by (1 + CDF) to make an internal tick. Each SCL period has a base length of 20 + 8×SCGD ticks. The base is split into a low phase and a high phase, and any odd tick goes to the low phase. When the low phase ends, the block releases SCL. It does not start timing the high phase until the SCL line is seen high again. As a result, slow rise times and targets that stretch the clock both lengthen the period, which gives clock synchronisation.

A single configuration word holds CDF in its lowest CDF_W bits and the 6-bit SCGD just above them. A separate 4-bit setup value sets how long SCL stays high after a START request before its first falling edge, which gives SDA time to settle. A setup value of 0x0F gives 17 input clocks. The configuration and setup values are captured only when `start_i` is accepted, so a change never reaches the bus in the middle of a transfer. The software that fills the configuration word must keep the tick rate at or below 20 MHz.

Top module: `scl_clkgen`

## Requirements
- R1: After reset, `scl_o` is 1 (released), `running_o` is 0, `tick_o` is 0 and `period_end_o` is 0.
- R2: The configuration word holds CDF in bits [CDF_W-1:0] and SCGD in bits [CDF_W+5:CDF_W]. While running, `tick_o` pulses once every CDF+1 input clocks during the low and high phases.
- R3: The low phase drives `scl_o` to 0 for exactly L×(CDF+1) input clocks, where B = 20 + 8×SCGD and L = B − floor(B/2).
- R4: If `scl_in_i` follows `scl_o`, `scl_o` stays high for exactly 1 + floor(B/2)×(CDF+1) input clocks. The extra clock is the cycle in which the rise is observed.
- R5: While `scl_in_i` is held low after release, the high-phase count does not start. Every clock of holding adds exactly one clock to the high time of `scl_o`.
- R6: After the clock edge that accepts `start_i`, `scl_o` stays high for S+2 input clocks before it falls, where S is the 4-bit setup value. The value 0x0F gives 17.
- R7: CDF, SCGD and the setup value are sampled only on the edge that accepts `start_i`. Changing the inputs while running has no effect until the next start.
- R8: `stop_i` returns the block to idle on the next edge: `scl_o` becomes 1 and `running_o` becomes 0. `start_i` takes priority over `stop_i`.
- R9: `period_end_o` is high for one clock, in the first cycle of each low phase that follows a high phase. It stays 0 on the first fall after the setup delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Capture the configuration and begin the setup delay |
| stop_i | input | 1 | Return to idle with SCL released |
| clk_cfg_i | input | CDF_W+6 | CDF in the low bits, SCGD above them |
| setup_cfg_i | input | 4 | First-edge setup delay value |
| scl_in_i | input | 1 | Sampled level of the SCL line |
| scl_o | output | 1 | 0 drives SCL low, 1 releases it |
| tick_o | output | 1 | Internal tick strobe |
| period_end_o | output | 1 | One-clock pulse at each completed SCL period |
| running_o | output | 1 | Generator is active |

## Verification
All timing is measured in input clocks. Each count starts at the edge that accepts `start_i` or at an `scl_o` transition, and ends at the next transition. The bench samples one time unit after every rising edge and stamps each sample with a free-running cycle counter. The lengths of setup (S+2), low (L×(CDF+1)) and high (1 + stretch + floor(B/2)×(CDF+1)) are therefore differences of stamps taken at the same point in the cycle. `stop_i` and the `period_end_o` pulse are checked in the first sample after the edge that causes them.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;

  localparam int SCGD_W = 6;
  localparam int LEN_W  = 10;
  localparam int SET_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_LOW   = 3'd2,
    ST_WAITH = 3'd3,
    ST_HIGH  = 3'd4
  } scl_state_e;

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int CDF_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CDF_W-1:0] div_sel,
  output logic             tick
);

  logic [CDF_W-1:0] pcnt;

  assign tick = en && (pcnt == div_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcnt <= '0;
    else if (!en)    pcnt <= '0;
    else if (tick)   pcnt <= '0;
    else             pcnt <= pcnt + 1'b1;
  end

  // R2: with a divider above one, ticks are never back to back
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_sel != '0 && $stable(div_sel)) |=> !tick);

endmodule

// File: rtl/scl_len_calc.sv
module scl_len_calc
  import scl_clkgen_pkg::*;
(
  input  logic [SCGD_W-1:0] scgd,
  output logic [LEN_W-1:0]  low_len,
  output logic [LEN_W-1:0]  high_len
);

  logic [LEN_W-1:0] base;

  always_comb begin
    base     = LEN_W'(20) + LEN_W'({scgd, 3'b000});
    high_len = base >> 1;
    low_len  = base - high_len;
  end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_clkgen_pkg::*;
#(
  parameter int CDF_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [CDF_W-1:0]  cdf_in,
  input  logic [SCGD_W-1:0] scgd_in,
  input  logic [SET_W-1:0]  setup_in,
  input  logic              scl_in,
  input  logic              tick,
  input  logic [LEN_W-1:0]  low_len,
  input  logic [LEN_W-1:0]  high_len,
  output logic [CDF_W-1:0]  cdf_q,
  output logic [SCGD_W-1:0] scgd_q,
  output logic              tick_en,
  output logic              scl_drv,
  output logic              period_end,
  output logic              running
);

  scl_state_e       state;
  logic [LEN_W-1:0] cnt;
  logic [SET_W-1:0] setup_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      cdf_q      <= '0;
      scgd_q     <= '0;
      setup_q    <= '0;
      period_end <= 1'b0;
    end else begin
      period_end <= 1'b0;
      if (start_i) begin
        state   <= ST_SETUP;
        cnt     <= '0;
        cdf_q   <= cdf_in;
        scgd_q  <= scgd_in;
        setup_q <= setup_in;
      end else if (stop_i) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        unique case (state)
          ST_SETUP: begin
            if (cnt == LEN_W'(setup_q) + LEN_W'(1)) begin
              state <= ST_LOW;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_LOW: if (tick) begin
            if (cnt == low_len - 1'b1) begin
              state <= ST_WAITH;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_WAITH: if (scl_in) state <= ST_HIGH;
          ST_HIGH: if (tick) begin
            if (cnt == high_len - 1'b1) begin
              state      <= ST_LOW;
              cnt        <= '0;
              period_end <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign tick_en = (state == ST_LOW) || (state == ST_HIGH);
  assign scl_drv = (state != ST_LOW);
  assign running = (state != ST_IDLE);

  // R7: captured configuration moves only on an accepted start
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(cdf_q) && $stable(scgd_q) && $stable(setup_q)));

  // R5: a low line keeps the generator waiting for the rise
  p_stretch_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAITH && !scl_in && !start_i && !stop_i) |=> state == ST_WAITH);

  // R9: a period ends only when leaving the high phase
  p_period_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> ($past(state) == ST_HIGH && state == ST_LOW));

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
  import scl_clkgen_pkg::*;
#(
  parameter int CDF_W = 3,
  localparam int CFG_W = CDF_W + SCGD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CFG_W-1:0] clk_cfg_i,
  input  logic [SET_W-1:0] setup_cfg_i,
  input  logic             scl_in_i,
  output logic             scl_o,
  output logic             tick_o,
  output logic             period_end_o,
  output logic             running_o
);

  logic [CDF_W-1:0]  cdf_q;
  logic [SCGD_W-1:0] scgd_q;
  logic [LEN_W-1:0]  low_len, high_len;
  logic              tick, tick_en;

  scl_len_calc u_len (
    .scgd     (scgd_q),
    .low_len  (low_len),
    .high_len (high_len)
  );

  scl_prescaler #(.CDF_W(CDF_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (tick_en),
    .div_sel (cdf_q),
    .tick    (tick)
  );

  scl_phase_fsm #(.CDF_W(CDF_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .cdf_in     (clk_cfg_i[CDF_W-1:0]),
    .scgd_in    (clk_cfg_i[CFG_W-1:CDF_W]),
    .setup_in   (setup_cfg_i),
    .scl_in     (scl_in_i),
    .tick       (tick),
    .low_len    (low_len),
    .high_len   (high_len),
    .cdf_q      (cdf_q),
    .scgd_q     (scgd_q),
    .tick_en    (tick_en),
    .scl_drv    (scl_o),
    .period_end (period_end_o),
    .running    (running_o)
  );

  assign tick_o = tick;

  // R8: stop without start releases the line on the next edge
  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> (scl_o && !running_o));

  // R2: no tick is produced while idle
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o |-> !tick_o);

endmodule

// File: tb/scl_clkgen_bench.sv
module scl_clkgen_bench;

  localparam int CLK_P = 10;
  localparam int CDF_W = 3;
  localparam int CFG_W = CDF_W + 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0;
  logic [CFG_W-1:0] clk_cfg_i = '0;
  logic [3:0] setup_cfg_i = '0;
  logic hold_low = 1'b0;
  logic scl_in_i;
  logic scl_o, tick_o, period_end_o, running_o;

  int n_checks = 0, n_fail = 0, cyc = 0;

  assign scl_in_i = scl_o & ~hold_low;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scl_clkgen #(.CDF_W(CDF_W)) u_scl_clkgen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .clk_cfg_i(clk_cfg_i), .setup_cfg_i(setup_cfg_i), .scl_in_i(scl_in_i),
    .scl_o(scl_o), .tick_o(tick_o), .period_end_o(period_end_o),
    .running_o(running_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wait_scl(input logic v);
    while (scl_o !== v) step();
  endtask

  function automatic int low_exp(input int scgd, input int cdf);
    int b = 20 + 8 * scgd;
    return (b - b / 2) * (cdf + 1);
  endfunction

  function automatic int high_exp(input int scgd, input int cdf);
    int b = 20 + 8 * scgd;
    return 1 + (b / 2) * (cdf + 1);
  endfunction

  task automatic do_start(input int scgd, input int cdf, input int setup);
    @(negedge clk);
    clk_cfg_i   = CFG_W'((scgd << CDF_W) | cdf);
    setup_cfg_i = 4'(setup);
    start_i     = 1'b1;
    step();
    start_i     = 1'b0;
  endtask

  task automatic t_reset();
    check(scl_o === 1'b1, "R1 scl", int'(scl_o), 1);
    check(running_o === 1'b0, "R1 running", int'(running_o), 0);
    check(tick_o === 1'b0 && period_end_o === 1'b0, "R1 strobes",
          int'(tick_o | period_end_o), 0);
  endtask

  // R6, R3, R4, R9 at the fastest setting
  task automatic t_basic();
    int n = 0, t0, t1, t2;
    do_start(0, 0, 15);
    while (scl_o === 1'b1) begin step(); n++; end
    check(n == 17, "R6 setup 0x0F", n, 17);
    check(period_end_o === 1'b0, "R9 no pulse after setup", int'(period_end_o), 0);
    t0 = cyc;
    wait_scl(1'b1); t1 = cyc;
    wait_scl(1'b0); t2 = cyc;
    check(t1 - t0 == low_exp(0, 0), "R3 low scgd0 cdf0", t1 - t0, low_exp(0, 0));
    check(t2 - t1 == high_exp(0, 0), "R4 high scgd0 cdf0", t2 - t1, high_exp(0, 0));
    check(period_end_o === 1'b1, "R9 pulse at fall", int'(period_end_o), 1);
    step();
    check(period_end_o === 1'b0, "R9 single cycle", int'(period_end_o), 0);
  endtask

  // R3, R4, R6 with a divider and a nonzero SCGD
  task automatic t_divided();
    int n = 0, t0, t1, t2;
    do_start(1, 2, 0);
    while (scl_o === 1'b1) begin step(); n++; end
    check(n == 2, "R6 setup zero", n, 2);
    t0 = cyc;
    wait_scl(1'b1); t1 = cyc;
    wait_scl(1'b0); t2 = cyc;
    check(t1 - t0 == low_exp(1, 2), "R3 low scgd1 cdf2", t1 - t0, low_exp(1, 2));
    check(t2 - t1 == high_exp(1, 2), "R4 high scgd1 cdf2", t2 - t1, high_exp(1, 2));
  endtask

  // R2: tick spacing and count within one low phase
  task automatic t_ticks();
    int ticks = 0, gap = 0, last = -1;
    bit gap_ok = 1'b1;
    do_start(0, 3, 0);
    wait_scl(1'b0);
    while (scl_o === 1'b0) begin
      if (tick_o === 1'b1) begin
        ticks++;
        if (last >= 0 && cyc - last != 4) begin gap_ok = 1'b0; gap = cyc - last; end
        last = cyc;
      end
      step();
    end
    check(ticks == 10, "R2 ticks in low", ticks, 10);
    check(gap_ok, "R2 tick spacing", gap, 4);
  endtask

  // R5: holding the line low after release lengthens the high time
  task automatic t_stretch();
    int t1, t2;
    do_start(0, 1, 0);
    wait_scl(1'b0);
    hold_low = 1'b1;
    wait_scl(1'b1); t1 = cyc;
    repeat (5) step();
    check(scl_o === 1'b1 && running_o === 1'b1, "R5 waiting while held",
          int'(scl_o), 1);
    hold_low = 1'b0;
    wait_scl(1'b0); t2 = cyc;
    check(t2 - t1 == 5 + high_exp(0, 1), "R5 stretched high",
          t2 - t1, 5 + high_exp(0, 1));
  endtask

  // R7: changing the inputs while running is ignored until restart
  task automatic t_cfg_latch();
    int t0, t1;
    do_start(0, 0, 0);
    wait_scl(1'b0);
    clk_cfg_i   = CFG_W'(2 << CDF_W);
    setup_cfg_i = 4'd9;
    wait_scl(1'b1);
    wait_scl(1'b0); t0 = cyc;
    wait_scl(1'b1); t1 = cyc;
    check(t1 - t0 == low_exp(0, 0), "R7 low unchanged mid-run", t1 - t0, low_exp(0, 0));
    do_start(2, 0, 0);
    wait_scl(1'b0); t0 = cyc;
    wait_scl(1'b1); t1 = cyc;
    check(t1 - t0 == low_exp(2, 0), "R7 new value after start", t1 - t0, low_exp(2, 0));
  endtask

  // R8: stop releases the line next edge
  task automatic t_stop();
    do_start(0, 0, 0);
    wait_scl(1'b0);
    @(negedge clk); stop_i = 1'b1;
    step(); stop_i = 1'b0;
    check(scl_o === 1'b1, "R8 scl released", int'(scl_o), 1);
    check(running_o === 1'b0, "R8 idle", int'(running_o), 0);
    repeat (30) step();
    check(scl_o === 1'b1 && tick_o === 1'b0, "R8 stays idle", int'(scl_o), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    step();
    t_basic();
    t_divided();
    t_ticks();
    t_stretch();
    t_cfg_latch();
    t_stop();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule